// File: doc/BRIEF.md
# UART Receive Special-Character Detector

This block sits between a UART receiver and its receive FIFO. Each character the receiver completes is written on to the FIFO one clock later. At the same time it is compared with a programmable match byte. When the compare hits, a sticky status bit and an interrupt request are raised, and the character is still stored in the FIFO.

Detection only works when the enable bit is set and all four software-flow-control select bits are zero. The compare covers only the bits of the configured word length (5 to 8 bits). A read of the interrupt status register clears the status bit.

Top module: `uart_spchar_detect`

## Requirements
- R1: While reset is held and in the first cycle after it, fifo_wr, spchar_status and irq are 0, so detection starts out disabled.
- R2: Every cycle with rx_valid=1 produces fifo_wr=1 in the next cycle. In that cycle fifo_data equals the received byte, unchanged, whether or not the compare hits.
- R3: A hit sets spchar_status in the same cycle as the fifo_wr for that character. A hit needs rx_valid=1, detect_en=1, swfc_mode=4'b0000 and equal compared bits.
- R4: Bit i of match_byte is compared with bit i of rx_data, with bit 0 the least significant bit of the character. A byte that is the bit-reversal of match_byte does not hit unless it equals match_byte.
- R5: If any bit of swfc_mode is 1, no hit is recorded. The character is still forwarded.
- R6: With detect_en=0, no hit is recorded. The character is still forwarded.
- R7: word_len selects the character width: 0→5, 1→6, 2→7, 3→8 bits. Bits at and above the width are left out of the compare.
- R8: spchar_status stays 1 until a cycle with isr_rd=1, and it is 0 in the cycle after that read. If a hit and isr_rd arrive in the same cycle, the status stays 1.
- R9: A character with rx_frame_err=1 is still compared and forwarded. fifo_frame_err carries the flag in the same cycle as fifo_wr and any resulting status set.
- R10: irq always equals spchar_status.
- R11: With rx_valid=0, fifo_wr is 0 in the next cycle and spchar_status does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Strobe for a completed received character |
| rx_data | input | 8 | Received character, bit 0 first on the line |
| rx_frame_err | input | 1 | Framing error flag for the character |
| word_len | input | 2 | Character width code (0→5 … 3→8 bits) |
| match_byte | input | 8 | Programmed match value |
| detect_en | input | 1 | Special-character detect enable |
| swfc_mode | input | 4 | Software-flow-control select bits; detection needs all zero |
| isr_rd | input | 1 | Interrupt-status read strobe, clears the sticky bit |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Character written to the FIFO |
| fifo_frame_err | output | 1 | Framing error flag stored with the character |
| spchar_status | output | 1 | Sticky special-character detected bit |
| irq | output | 1 | Interrupt request |

## Verification
The compare is tried with several input patterns, and each one separates a different faulty behaviour:
- An exact 8-bit match and a lone differing bit tell a working equality check from one that ignores some bits.
- A byte and its bit-reversal show whether bit order is kept.
- Bytes that differ only above the configured width, tried at widths 5, 6 and 8, show whether the mask tracks word_len.
- The same matching byte is also sent under each nonzero flow-control bit, with the enable off, with a framing error, and together with a status read. This shows that suppression, pass-through and set-over-clear priority are separate from the compare itself.

// File: rtl/spd_pkg.sv
// Package: shared parameters and the forwarded-character record for the
// special-character detector. Assumes characters are at most 8 bits.
package spd_pkg;
    localparam int DATA_W = 8;
    localparam int MIN_W  = 5;
    localparam int LEN_W  = 2;
    localparam int MODE_W = 4;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              frame_err;
    } rx_char_t;
endpackage

// File: rtl/spd_len_mask.sv
// Module: spd_len_mask
// Turns the word-length code into a per-bit compare mask. Bit i is set when
// i < MIN_W + word_len. Assumes MIN_W + 2**LEN_W - 1 >= DATA_W.
module spd_len_mask #(
    parameter int DATA_W = 8,
    parameter int MIN_W  = 5,
    parameter int LEN_W  = 2
) (
    input  logic [LEN_W-1:0]  word_len,
    output logic [DATA_W-1:0] mask
);
    logic [31:0] width_bits;

    // Active width in bits.
    always_comb width_bits = 32'(MIN_W) + 32'(word_len);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // One mask bit per character bit position.
        assign mask[i] = (width_bits > 32'(i));
    end
endmodule

// File: rtl/spd_compare.sv
// Module: spd_compare
// Combinational hit decision. The match register and the received character
// are compared bit for bit. The compare is qualified by the enable bit and
// by the flow-control select bits being all zero.
module spd_compare #(
    parameter int DATA_W = 8,
    parameter int MODE_W = 4
) (
    input  logic [DATA_W-1:0] rx_data,
    input  logic [DATA_W-1:0] match_byte,
    input  logic [DATA_W-1:0] mask,
    input  logic              rx_valid,
    input  logic              detect_en,
    input  logic [MODE_W-1:0] swfc_mode,
    output logic              hit
);
    logic [DATA_W-1:0] diff;
    logic              allowed;

    for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
        // Mismatch at bit i, counted only inside the active width.
        assign diff[i] = (rx_data[i] ^ match_byte[i]) & mask[i];
    end

    // Detection is permitted only with software flow control fully off.
    always_comb allowed = detect_en && (swfc_mode == '0);

    // Final hit for this cycle's character.
    always_comb hit = rx_valid && allowed && (diff == '0);
endmodule

// File: rtl/spd_wr_stage.sv
// Module: spd_wr_stage
// One register stage that forwards every received character to the FIFO
// unchanged. Assumes the FIFO accepts a write on every strobe.
module spd_wr_stage
    import spd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  rx_char_t in_char,
    output logic     out_wr,
    output rx_char_t out_char
);
    // Register the write strobe and the character record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_wr   <= 1'b0;
            out_char <= '0;
        end else begin
            out_wr <= in_valid;
            if (in_valid) out_char <= in_char;
        end
    end
endmodule

// File: rtl/spd_status.sv
// Module: spd_status
// Sticky detect bit. A set wins over a clear in the same cycle, so no event
// is lost. Because the bit is registered, it rises in the same cycle as the
// forwarded FIFO write.
module spd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold, set or clear the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/uart_spchar_detect.sv
// Module: uart_spchar_detect (top)
// Forwards every received character to the receive FIFO, one cycle late.
// Flags a sticky special-character event when a character matches the
// programmed byte within the active word width. Assumes rx_valid is a
// single-cycle strobe per character, and that the register inputs are
// stable around the strobe.
module uart_spchar_detect
    import spd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_frame_err,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [DATA_W-1:0] match_byte,
    input  logic              detect_en,
    input  logic [MODE_W-1:0] swfc_mode,
    input  logic              isr_rd,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_frame_err,
    output logic              spchar_status,
    output logic              irq
);
    logic [DATA_W-1:0] cmp_mask;
    logic              hit;
    rx_char_t          in_char;
    rx_char_t          out_char;

    // Pack the incoming character record.
    always_comb begin
        in_char.data      = rx_data;
        in_char.frame_err = rx_frame_err;
    end

    spd_len_mask #(.DATA_W(DATA_W), .MIN_W(MIN_W), .LEN_W(LEN_W)) u_mask (
        .word_len (word_len),
        .mask     (cmp_mask)
    );

    spd_compare #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_cmp (
        .rx_data    (rx_data),
        .match_byte (match_byte),
        .mask       (cmp_mask),
        .rx_valid   (rx_valid),
        .detect_en  (detect_en),
        .swfc_mode  (swfc_mode),
        .hit        (hit)
    );

    spd_wr_stage u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_char  (in_char),
        .out_wr   (fifo_wr),
        .out_char (out_char)
    );

    spd_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit),
        .clr_i  (isr_rd),
        .flag_o (spchar_status)
    );

    // Unpack the forwarded record and drive the interrupt.
    always_comb begin
        fifo_data      = out_char.data;
        fifo_frame_err = out_char.frame_err;
        irq            = spchar_status;
    end
endmodule

// File: rtl/spd_checker.sv
// Module: spd_checker
// Property checks for uart_spchar_detect, attached through bind.
module spd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_frame_err,
    input logic [1:0] word_len,
    input logic [7:0] match_byte,
    input logic       detect_en,
    input logic [3:0] swfc_mode,
    input logic       isr_rd,
    input logic       fifo_wr,
    input logic [7:0] fifo_data,
    input logic       fifo_frame_err,
    input logic       spchar_status,
    input logic       irq
);
    a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> fifo_wr && fifo_data == $past(rx_data));

    a_r3_full_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && detect_en && swfc_mode == 4'b0000 && word_len == 2'd3
         && rx_data == match_byte) |=> spchar_status);

    a_r3_rise_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spchar_status) |-> fifo_wr);

    a_r5_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (swfc_mode != 4'b0000 && !spchar_status) |=> !spchar_status);

    a_r6_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!detect_en && !spchar_status) |=> !spchar_status);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (spchar_status && !isr_rd) |=> spchar_status);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && !rx_valid) |=> !spchar_status);

    a_r9_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> fifo_frame_err == $past(rx_frame_err));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !fifo_wr && !$rose(spchar_status));

    // R10: interrupt follows the status bit.
    always_comb begin
        if (rst_n) begin
            a_r10_irq: assert (irq == spchar_status);
        end
    end
endmodule

bind uart_spchar_detect spd_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid       (rx_valid),
    .rx_data        (rx_data),
    .rx_frame_err   (rx_frame_err),
    .word_len       (word_len),
    .match_byte     (match_byte),
    .detect_en      (detect_en),
    .swfc_mode      (swfc_mode),
    .isr_rd         (isr_rd),
    .fifo_wr        (fifo_wr),
    .fifo_data      (fifo_data),
    .fifo_frame_err (fifo_frame_err),
    .spchar_status  (spchar_status),
    .irq            (irq)
);

// File: tb/uart_spchar_detect_tb.sv
// Directed bench for uart_spchar_detect. Inputs change on the falling edge
// and outputs are sampled on the falling edge after the capturing rising edge.
module uart_spchar_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_frame_err = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic [7:0] match_byte = '0;
    logic       detect_en = 1'b0;
    logic [3:0] swfc_mode = '0;
    logic       isr_rd = 1'b0;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic       fifo_frame_err;
    logic       spchar_status;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_spchar_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .word_len(word_len),
        .match_byte(match_byte), .detect_en(detect_en),
        .swfc_mode(swfc_mode), .isr_rd(isr_rd), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .fifo_frame_err(fifo_frame_err),
        .spchar_status(spchar_status), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected hit from the requirements (R3, R5, R6, R7).
    function automatic bit model_hit(input logic [7:0] d);
        int w = 5 + int'(word_len);
        bit eq = 1'b1;
        for (int i = 0; i < w; i++) if (d[i] != match_byte[i]) eq = 1'b0;
        return eq && detect_en && (swfc_mode == 4'b0000);
    endfunction

    // Read the status register: the bit is clear one cycle later (R8).
    task automatic clear_status();
        @(negedge clk); isr_rd = 1'b1;
        @(negedge clk); isr_rd = 1'b0;
        check("R8 clear", int'(spchar_status), 0);
    endtask

    // Send one character and check forwarding and status in the write cycle.
    task automatic send(input string req, input logic [7:0] d, input logic fe,
                        input bit exp_status);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_frame_err = fe;
        @(negedge clk);
        rx_valid = 1'b0;
        check({req, " R2 wr"}, int'(fifo_wr), 1);
        check({req, " R2 data"}, int'(fifo_data), int'(d));
        check({req, " R9 fe"}, int'(fifo_frame_err), int'(fe));
        check({req, " status"}, int'(spchar_status), int'(exp_status));
        check({req, " R10 irq"}, int'(irq), int'(exp_status));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 wr", int'(fifo_wr), 0);
        check("R1 status", int'(spchar_status), 0);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after wr", int'(fifo_wr), 0);
        check("R1 after status", int'(spchar_status), 0);
    endtask

    task automatic t_basic_match();
        match_byte = 8'hA5; detect_en = 1'b1; word_len = 2'd3;
        send("R3 A5", 8'hA5, 1'b0, model_hit(8'hA5));
        clear_status();
        send("R3 one bit off", 8'hA4, 1'b0, model_hit(8'hA4));
    endtask

    task automatic t_bit_order();
        match_byte = 8'h01;
        send("R4 reversed", 8'h80, 1'b0, model_hit(8'h80));
        send("R4 direct", 8'h01, 1'b0, 1'b1);
        clear_status();
        match_byte = 8'h0B;
        send("R4 rev 0B", 8'hD0, 1'b0, 1'b0);
    endtask

    task automatic t_mode_block();
        match_byte = 8'h3C;
        for (int b = 0; b < 4; b++) begin
            swfc_mode = 4'(1 << b);
            send("R5 mode", 8'h3C, 1'b0, 1'b0);
        end
        swfc_mode = 4'b0000;
    endtask

    task automatic t_disable();
        detect_en = 1'b0;
        send("R6 off", 8'h3C, 1'b0, 1'b0);
        detect_en = 1'b1;
    endtask

    task automatic t_width();
        match_byte = 8'h13;
        word_len = 2'd0;
        send("R7 w5 hit", 8'hF3, 1'b0, model_hit(8'hF3));
        clear_status();
        word_len = 2'd3;
        send("R7 w8 miss", 8'hF3, 1'b0, model_hit(8'hF3));
        word_len = 2'd1;
        send("R7 w6 hit", 8'h53, 1'b0, model_hit(8'h53));
        clear_status();
        send("R7 w6 miss", 8'h33, 1'b0, model_hit(8'h33));
        word_len = 2'd3;
    endtask

    task automatic t_sticky();
        match_byte = 8'h7E;
        send("R8 set", 8'h7E, 1'b0, 1'b1);
        send("R8 hold miss", 8'h00, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check("R8 hold idle", int'(spchar_status), 1);
        check("R11 idle wr", int'(fifo_wr), 0);
        clear_status();
        // Hit and read in the same cycle: the set wins.
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h7E; isr_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; isr_rd = 1'b0;
        check("R8 set wins", int'(spchar_status), 1);
        clear_status();
    endtask

    task automatic t_frame_err();
        match_byte = 8'h55;
        send("R9 fe hit", 8'h55, 1'b1, 1'b1);
        clear_status();
        send("R9 fe miss", 8'h56, 1'b1, 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R11 no wr", int'(fifo_wr), 0);
        check("R11 no status", int'(spchar_status), 0);
    endtask

    initial begin
        t_reset();
        t_basic_match();
        t_bit_order();
        t_mode_block();
        t_disable();
        t_width();
        t_sticky();
        t_frame_err();
        t_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule